// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It reads descriptors from a translation table that sits in physical memory. A request gives a virtual address. The walker combines it with the table base to form a first-level fetch address and issues one read on a plain memory port. It then decodes the low two bits of the word that comes back. Depending on those bits, the walk either finishes with a 1 MB mapping, moves on to a second-level coarse table with 4 KB pages, or stops with a translation fault.

The walker handles one walk at a time. Its own table reads go straight to physical memory and are never translated. The result appears for one cycle, together with a done pulse. It carries the physical address, the cacheable and bufferable flags, the 4-bit domain number and a fault flag with the level that faulted. The block does not cache results and does not check access permissions.

Top module: `ttw_walker`

## Requirements
- R1: After reset, busy_o, done_o and mem_rd_o are all low.
- R2: The first fetch reads address {tbase_i[31:14], vaddr[31:20], 2'b00}. Table base bits 13:0 have no effect.
- R3: A first-level word with bits[1:0] = 2'b10 completes the walk with paddr = {word[31:20], vaddr[19:0]}, cacheable = word[3], bufferable = word[2] and domain = word[8:5], after exactly one fetch.
- R4: A first-level word with bits[1:0] = 2'b01 causes a second fetch at {word[31:10], vaddr[19:12], 2'b00}.
- R5: A second-level word with bits[1:0] equal to 2'b10 or 2'b11 completes the walk with paddr = {word[31:12], vaddr[11:0]}, cacheable = word[3] and bufferable = word[2]. The domain comes from bits 8:5 of the first-level word.
- R6: A first-level word with bits[1:0] equal to 2'b00 or 2'b11 sets fault_o = 1 and fault_lvl_o = 0, with paddr, cacheable, bufferable and domain all zero, after one fetch.
- R7: A second-level word with bits[1:0] = 2'b00 sets fault_o = 1 and fault_lvl_o = 1, with paddr, cacheable, bufferable and domain all zero.
- R8: A request is accepted only when the walker is idle. busy_o goes high on the edge that accepts it and stays high through a single-cycle done_o pulse, then falls. Requests raised while busy have no effect on the result.
- R9: Each fetch is a one-cycle mem_rd_o pulse. mem_addr_o is held until the matching mem_rvalid_i arrives.
- R10: Results are correct for any memory latency of one or more cycles after the read pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbase_i | input | 32 | Translation table base; bits 13:0 ignored |
| req_valid_i | input | 1 | Translation request, taken when idle |
| req_vaddr_i | input | 32 | Virtual address to translate |
| busy_o | output | 1 | Walk in progress |
| mem_addr_o | output | 32 | Physical address of descriptor fetch |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_rdata_i | input | 32 | Returned descriptor word |
| mem_rvalid_i | input | 1 | Returned word valid |
| done_o | output | 1 | One-cycle completion pulse |
| paddr_o | output | 32 | Physical address (zero on fault) |
| cacheable_o | output | 1 | Cacheable attribute |
| bufferable_o | output | 1 | Bufferable attribute |
| domain_o | output | 4 | Domain number |
| fault_o | output | 1 | Translation fault |
| fault_lvl_o | output | 1 | 0: first-level fault, 1: second-level fault |

## Verification
The hardest case to reach from the ports is a new request that arrives while a two-level walk is still waiting for memory. The bench causes it by keeping req_valid_i high with a different address during each wait window of a slow walk. It then checks that both fetch addresses and the final result still belong to the first request. The second-level decode only runs after a coarse first-level word. For that reason the bench memory model answers each read with a word chosen by fetch order, and it records every address that was issued. This lets the walk take each descriptor-type path, including the second-level fault.

// File: rtl/ttw_pkg.sv
// Shared constants and types for the translation table walker.
// Assumes a 32-bit physical and virtual address space with word-sized descriptors.
package ttw_pkg;
    localparam int ADDR_W     = 32;
    localparam int SEC_SHIFT  = 20;  // 1 MB mapping granule
    localparam int PAGE_SHIFT = 12;  // 4 KB mapping granule
    localparam int DOM_W      = 4;
    localparam int DOM_LSB    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        STEP_FINAL,
        STEP_NEXT,
        STEP_FAULT
    } step_t;

    typedef struct packed {
        step_t              step;
        logic [ADDR_W-1:0]  paddr;
        logic               cacheable;
        logic               bufferable;
        logic [DOM_W-1:0]   domain;
    } step_res_t;
endpackage

// File: rtl/ttw_fetch_addr.sv
// Forms the two descriptor fetch addresses from the table base, the virtual
// address and the stored coarse-table pointer. Purely combinational.
// Assumes word descriptors, so both addresses end in two zero bits.
module ttw_fetch_addr #(
    parameter int AW         = ttw_pkg::ADDR_W,
    parameter int SEC_SHIFT  = ttw_pkg::SEC_SHIFT,
    parameter int PAGE_SHIFT = ttw_pkg::PAGE_SHIFT,
    localparam int BASE_LSB  = AW - SEC_SHIFT + 2,
    localparam int PTR_LSB   = SEC_SHIFT - PAGE_SHIFT + 2
) (
    input  logic [AW-1:BASE_LSB] base_i,
    input  logic [AW-1:0]        vaddr_i,
    input  logic [AW-1:PTR_LSB]  l2_ptr_i,
    input  logic                 sel_l2_i,
    output logic [AW-1:0]        fetch_addr_o
);
    logic [AW-1:0] l1_addr;
    logic [AW-1:0] l2_addr;
    logic          unused_va;

    // Index the first-level table with the top virtual bits.
    assign l1_addr = {base_i, vaddr_i[AW-1:SEC_SHIFT], 2'b00};
    // Index the coarse table with the middle virtual bits.
    assign l2_addr = {l2_ptr_i, vaddr_i[SEC_SHIFT-1:PAGE_SHIFT], 2'b00};
    // Pick the address of the level being fetched.
    assign fetch_addr_o = sel_l2_i ? l2_addr : l1_addr;
    assign unused_va = ^vaddr_i[PAGE_SHIFT-1:0];
endmodule

// File: rtl/ttw_desc_decode.sv
// Decodes one fetched descriptor. LEVEL2 picks the first-level or the
// second-level variant. A fault returns all-zero attributes and address.
// Assumes the caller uses the result only in the cycle the word is valid.
module ttw_desc_decode #(
    parameter int AW         = ttw_pkg::ADDR_W,
    parameter int SEC_SHIFT  = ttw_pkg::SEC_SHIFT,
    parameter int PAGE_SHIFT = ttw_pkg::PAGE_SHIFT,
    parameter int DOM_W      = ttw_pkg::DOM_W,
    parameter int DOM_LSB    = ttw_pkg::DOM_LSB,
    parameter bit LEVEL2     = 1'b0
) (
    input  logic [AW-1:0]        desc_i,
    input  logic [AW-1:0]        vaddr_i,
    input  logic [DOM_W-1:0]     l1_domain_i,
    output ttw_pkg::step_res_t   res_o
);
    import ttw_pkg::*;

    generate
        if (!LEVEL2) begin : g_level1
            logic unused_l1;
            assign unused_l1 = ^{desc_i[SEC_SHIFT-1:DOM_LSB+DOM_W], desc_i[4],
                                 vaddr_i[AW-1:SEC_SHIFT], l1_domain_i};
            // First-level type decode: section, coarse pointer or fault.
            always_comb begin
                res_o = '0;
                res_o.step = STEP_FAULT;
                unique case (desc_i[1:0])
                    2'b10: begin
                        res_o.step       = STEP_FINAL;
                        res_o.paddr      = {desc_i[AW-1:SEC_SHIFT], vaddr_i[SEC_SHIFT-1:0]};
                        res_o.cacheable  = desc_i[3];
                        res_o.bufferable = desc_i[2];
                        res_o.domain     = desc_i[DOM_LSB+DOM_W-1:DOM_LSB];
                    end
                    2'b01: begin
                        res_o.step   = STEP_NEXT;
                        res_o.domain = desc_i[DOM_LSB+DOM_W-1:DOM_LSB];
                    end
                    default: res_o.step = STEP_FAULT;
                endcase
            end
        end else begin : g_level2
            logic unused_l2;
            assign unused_l2 = ^{desc_i[PAGE_SHIFT-1:4], vaddr_i[AW-1:PAGE_SHIFT]};
            // Second-level type decode: small page or fault.
            always_comb begin
                res_o = '0;
                if (desc_i[1:0] == 2'b00) begin
                    res_o.step = STEP_FAULT;
                end else begin
                    res_o.step       = STEP_FINAL;
                    res_o.paddr      = {desc_i[AW-1:PAGE_SHIFT], vaddr_i[PAGE_SHIFT-1:0]};
                    res_o.cacheable  = desc_i[3];
                    res_o.bufferable = desc_i[2];
                    res_o.domain     = l1_domain_i;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ttw_ctrl.sv
// Walk sequencer. Accepts a request only when idle, issues one-cycle read
// strobes, waits for the returned word and ends with a one-cycle done state.
// Assumes the memory returns exactly one valid word for each read strobe.
module ttw_ctrl (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             mem_rvalid_i,
    input  ttw_pkg::step_t   l1_step_i,
    output logic             mem_rd_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             load_req_o,
    output logic             take_l1_o,
    output logic             take_l2_o,
    output logic             sel_l2_o
);
    import ttw_pkg::*;

    walk_state_t state_q, state_d;

    // Next-state choice, driven by the descriptor type at first level.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid_i) state_d = ST_L1_REQ;
            ST_L1_REQ:  state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rvalid_i)
                            state_d = (l1_step_i == STEP_NEXT) ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rvalid_i) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign mem_rd_o   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = (state_q == ST_DONE);
    assign load_req_o = (state_q == ST_IDLE) && req_valid_i;
    assign take_l1_o  = (state_q == ST_L1_WAIT) && mem_rvalid_i;
    assign take_l2_o  = (state_q == ST_L2_WAIT) && mem_rvalid_i;
    assign sel_l2_o   = (state_q == ST_L2_REQ) || (state_q == ST_L2_WAIT);

    // R9
    rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);
    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R8
    done_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    // R9
    rd_done_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, done_o}));
    // R8
    accept_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/ttw_walker.sv
// Two-level translation table walker top. Holds the request, the coarse
// table pointer and the result registers, and wires the address former,
// both descriptor decoders and the sequencer together.
// Assumes table fetches address physical memory directly.
module ttw_walker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] tbase_i,
    input  logic        req_valid_i,
    input  logic [31:0] req_vaddr_i,
    output logic        busy_o,
    output logic [31:0] mem_addr_o,
    output logic        mem_rd_o,
    input  logic [31:0] mem_rdata_i,
    input  logic        mem_rvalid_i,
    output logic        done_o,
    output logic [31:0] paddr_o,
    output logic        cacheable_o,
    output logic        bufferable_o,
    output logic [3:0]  domain_o,
    output logic        fault_o,
    output logic        fault_lvl_o
);
    import ttw_pkg::*;

    localparam int AW       = ADDR_W;
    localparam int BASE_LSB = AW - SEC_SHIFT + 2;
    localparam int PTR_LSB  = SEC_SHIFT - PAGE_SHIFT + 2;

    logic [AW-1:BASE_LSB] base_q;
    logic [AW-1:0]        va_q;
    logic [AW-1:PTR_LSB]  l2_ptr_q;
    logic [DOM_W-1:0]     l1_dom_q;
    logic [AW-1:0]        paddr_q;
    logic                 c_q, b_q, fault_q, lvl_q;
    logic [DOM_W-1:0]     dom_q;

    logic load_req, take_l1, take_l2, sel_l2;
    step_res_t res_l1, res_l2;
    logic unused_base;

    assign unused_base = ^tbase_i[BASE_LSB-1:0];

    ttw_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .mem_rvalid_i (mem_rvalid_i),
        .l1_step_i    (res_l1.step),
        .mem_rd_o     (mem_rd_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .load_req_o   (load_req),
        .take_l1_o    (take_l1),
        .take_l2_o    (take_l2),
        .sel_l2_o     (sel_l2)
    );

    ttw_fetch_addr #(.AW(AW)) u_addr (
        .base_i       (base_q),
        .vaddr_i      (va_q),
        .l2_ptr_i     (l2_ptr_q),
        .sel_l2_i     (sel_l2),
        .fetch_addr_o (mem_addr_o)
    );

    ttw_desc_decode #(.AW(AW), .LEVEL2(1'b0)) u_dec_l1 (
        .desc_i      (mem_rdata_i),
        .vaddr_i     (va_q),
        .l1_domain_i (l1_dom_q),
        .res_o       (res_l1)
    );

    ttw_desc_decode #(.AW(AW), .LEVEL2(1'b1)) u_dec_l2 (
        .desc_i      (mem_rdata_i),
        .vaddr_i     (va_q),
        .l1_domain_i (l1_dom_q),
        .res_o       (res_l2)
    );

    // Capture the request, the coarse pointer and the walk result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            va_q     <= '0;
            l2_ptr_q <= '0;
            l1_dom_q <= '0;
            paddr_q  <= '0;
            c_q      <= 1'b0;
            b_q      <= 1'b0;
            dom_q    <= '0;
            fault_q  <= 1'b0;
            lvl_q    <= 1'b0;
        end else if (load_req) begin
            base_q   <= tbase_i[AW-1:BASE_LSB];
            va_q     <= req_vaddr_i;
            paddr_q  <= '0;
            c_q      <= 1'b0;
            b_q      <= 1'b0;
            dom_q    <= '0;
            fault_q  <= 1'b0;
            lvl_q    <= 1'b0;
        end else if (take_l1) begin
            l2_ptr_q <= mem_rdata_i[AW-1:PTR_LSB];
            l1_dom_q <= res_l1.domain;
            if (res_l1.step != STEP_NEXT) begin
                paddr_q <= res_l1.paddr;
                c_q     <= res_l1.cacheable;
                b_q     <= res_l1.bufferable;
                dom_q   <= res_l1.domain;
                fault_q <= (res_l1.step == STEP_FAULT);
                lvl_q   <= 1'b0;
            end
        end else if (take_l2) begin
            paddr_q <= res_l2.paddr;
            c_q     <= res_l2.cacheable;
            b_q     <= res_l2.bufferable;
            dom_q   <= res_l2.domain;
            fault_q <= (res_l2.step == STEP_FAULT);
            lvl_q   <= (res_l2.step == STEP_FAULT);
        end
    end

    assign paddr_o      = paddr_q;
    assign cacheable_o  = c_q;
    assign bufferable_o = b_q;
    assign domain_o     = dom_q;
    assign fault_o      = fault_q;
    assign fault_lvl_o  = lvl_q;

    // R9
    fetch_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> $stable(mem_addr_o));
    // R8
    req_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(va_q));
    // R6
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (paddr_o == '0 && !cacheable_o && !bufferable_o));
    // R2
    fetch_word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (mem_addr_o[1:0] == 2'b00));
endmodule

// File: tb/tb_ttw_walker.sv
`timescale 1ns/1ps
module tb_ttw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbase_i = '0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_vaddr_i = '0;
    logic        busy_o, mem_rd_o, done_o;
    logic [31:0] mem_addr_o, paddr_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_rvalid_i = 1'b0;
    logic        cacheable_o, bufferable_o, fault_o, fault_lvl_o;
    logic [3:0]  domain_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] g_pa, g_a1, g_a2;
    logic        g_c, g_b, g_f, g_l;
    logic [3:0]  g_dom;
    int          g_n;

    always #2 clk = ~clk;

    ttw_walker dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one walk; answer reads with l1d then l2d after lat cycles.
    task automatic run_walk(input logic [31:0] base, input logic [31:0] va,
                            input logic [31:0] l1d, input logic [31:0] l2d,
                            input int lat, input bit junk);
        int cnt = 0;
        bit fin = 0;
        g_n = 0; g_a1 = '0; g_a2 = '0;
        @(negedge clk);
        tbase_i = base; req_vaddr_i = va; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        check(busy_o == 1'b1, "R8 busy after accept", {31'd0, busy_o}, 32'd1);
        for (int i = 0; i < 300 && !fin; i++) begin
            if (i != 0) @(negedge clk);
            mem_rvalid_i = 1'b0;
            if (done_o) begin
                g_pa = paddr_o; g_c = cacheable_o; g_b = bufferable_o;
                g_dom = domain_o; g_f = fault_o; g_l = fault_lvl_o;
                fin = 1;
            end else if (mem_rd_o) begin
                if (g_n == 0) g_a1 = mem_addr_o; else g_a2 = mem_addr_o;
                g_n++;
                cnt = lat;
                if (junk) begin req_valid_i = 1'b1; req_vaddr_i = ~va; tbase_i = ~base; end
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i = (g_n == 1) ? l1d : l2d;
                    req_valid_i = 1'b0;
                end
            end
        end
        check(fin, "R8 walk completes", {31'd0, fin}, 32'd1);
        @(negedge clk);
        check(!busy_o && !done_o, "R8 done single cycle then idle",
              {30'd0, busy_o, done_o}, 32'd0);
    endtask

    task automatic t_reset;
        check(!busy_o && !done_o && !mem_rd_o, "R1 reset state",
              {29'd0, busy_o, done_o, mem_rd_o}, 32'd0);
    endtask

    task automatic t_section_basic;
        run_walk(32'h0000_4000, 32'h1234_5678, 32'hABC0_0002, 32'h0, 1, 0);
        check(g_a1 == 32'h0000_448C, "R2 l1 fetch addr", g_a1, 32'h448C);
        check(g_n == 1, "R3 one fetch", g_n, 1);
        check(g_pa == 32'hABC4_5678 && !g_f, "R3 section paddr", g_pa, 32'hABC45678);
    endtask

    task automatic t_section_attr;
        run_walk(32'h0001_C123, 32'hFFF0_0ABC, 32'h8010_012E, 32'h0, 3, 0);
        check(g_a1 == 32'h0001_FFFC, "R2 base low bits ignored", g_a1, 32'h1FFFC);
        check(g_pa == 32'h8010_0ABC, "R3 section paddr", g_pa, 32'h80100ABC);
        check({g_c, g_b, g_dom} == {1'b1, 1'b1, 4'd9}, "R3 section attrs",
              {26'd0, g_c, g_b, g_dom}, {26'd0, 6'b11_1001});
    endtask

    task automatic t_coarse_page;
        run_walk(32'h0000_4000, 32'h1234_5678, 32'hABCD_E0A1, 32'h5566_700E, 2, 0);
        check(g_a2 == 32'hABCD_E114, "R4 l2 fetch addr", g_a2, 32'hABCDE114);
        check(g_pa == 32'h5566_7678 && !g_f, "R5 page paddr", g_pa, 32'h55667678);
        check({g_c, g_b, g_dom} == {1'b1, 1'b1, 4'd5}, "R5 page attrs and l1 domain",
              {26'd0, g_c, g_b, g_dom}, {26'd0, 6'b11_0101});
    endtask

    task automatic t_page_type11;
        run_walk(32'h0000_8000, 32'h7FF0_1234, 32'h0010_0001, 32'h00AB_C007, 1, 0);
        check(g_a1 == 32'h0000_9FFC, "R2 l1 fetch addr", g_a1, 32'h9FFC);
        check(g_a2 == 32'h0010_0004, "R4 l2 fetch addr", g_a2, 32'h00100004);
        check(g_pa == 32'h00AB_C234, "R5 page type 11 paddr", g_pa, 32'h00ABC234);
        check({g_c, g_b} == 2'b01, "R5 page C/B", {30'd0, g_c, g_b}, 32'd1);
    endtask

    task automatic t_l1_faults;
        run_walk(32'h0000_4000, 32'h1234_5678, 32'hABC0_012C, 32'h0, 2, 0);
        check(g_f && !g_l && g_n == 1, "R6 type 00 fault", {30'd0, g_f, g_l}, 32'd2);
        check(g_pa == 0 && {g_c, g_b, g_dom} == 0, "R6 fault zero outputs", g_pa, 32'd0);
        run_walk(32'h0000_4000, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0, 1, 0);
        check(g_f && !g_l && g_n == 1, "R6 type 11 fault", {30'd0, g_f, g_l}, 32'd2);
        check(g_pa == 0 && {g_c, g_b, g_dom} == 0, "R6 fault zero outputs", g_pa, 32'd0);
    endtask

    task automatic t_l2_fault;
        run_walk(32'h0000_4000, 32'h0030_0000, 32'h0020_0001, 32'hFFFF_FFFC, 2, 0);
        check(g_f && g_l && g_n == 2, "R7 l2 fault", {30'd0, g_f, g_l}, 32'd3);
        check(g_pa == 0 && {g_c, g_b, g_dom} == 0, "R7 fault zero outputs", g_pa, 32'd0);
    endtask

    task automatic t_busy_ignore;
        run_walk(32'h0000_4000, 32'h1234_5678, 32'hABCD_E0A1, 32'h5566_700E, 7, 1);
        check(g_a1 == 32'h0000_448C && g_a2 == 32'hABCD_E114, "R8 R9 addrs unaffected by busy requests",
              g_a2, 32'hABCDE114);
        check(g_pa == 32'h5566_7678 && g_n == 2, "R8 R10 result unaffected, slow memory",
              g_pa, 32'h55667678);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_section_basic();
        t_section_attr();
        t_coarse_page();
        t_page_type11();
        t_l1_faults();
        t_l2_fault();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule